// File: doc/BRIEF.md
# Indexed-Colour Pixel Framebuffer Controller

This block is a bus peripheral that owns a frame of 8-bit colour indices and gives a processor access to it through a small register window. The processor first loads a row register and a column register. It then moves one pixel at a time through a single data register, which always addresses the pixel at the latched row and column. A separate register acts as a strobe: writing it asks the display side to pick up the frame, and the block shows that request as a one-cycle pulse.

The frame geometry is set by parameters. The full-screen configuration is 320 pixels by 240 rows (`IMG_W=320`, `IMG_H=240`). The defaults build a reduced 64 by 48 tile with the same 4:3 shape, which keeps the elaborated storage small. The pixel at row r and column c lives at linear address r × IMG_W + c. A fixed eight-entry colour table turns any pixel index into 24-bit RGB for a read-out port that has no connection to the bus side.

Bus reads return data one cycle after they are accepted, marked by a valid strobe. Misuse raises a sticky error flag that only reset clears. Misuse means an offset beyond the four defined ones, or a pixel read while the row or column lies outside the frame.

Top module: `pixfb_ctrl`

## Requirements
- R1: Offset 0 is the row register and offset 1 is the column register. Each holds a full 16-bit value, is readable and writable, resets to 0, and keeps its value across pixel reads and writes.
- R2: A write to offset 2 with the position inside the frame stores bits [7:0] of the write data at linear address row × IMG_W + column. Bits [15:8] are dropped, and no other pixel changes.
- R3: A read of offset 2 with the position inside the frame returns the stored pixel in bits [7:0], with bits [15:8] zero.
- R4: A write to offset 3 drives `refresh_pulse` high for exactly the one cycle after the write, whatever the write data. A read of offset 3 returns 0. Neither access changes the row, the column or any pixel.
- R5: Every accepted read (select high, write enable low) raises `bus_rvalid` for exactly the following cycle, with `bus_rdata` valid in that cycle. Writes never raise `bus_rvalid`.
- R6: An access to offsets 4 to 7 changes no register and no pixel, and sets the error flag. Such a read returns 0.
- R7: A pixel write while the row is at or above IMG_H, or the column is at or above IMG_W, modifies no pixel. This includes the in-frame pixel whose linear address the out-of-range position would alias to.
- R8: A pixel read with the position outside the frame returns 0 and sets the error flag.
- R9: `err_flag` is 0 after reset. Once set it stays set until the next reset. It becomes visible in the cycle after the faulting access.
- R10: `pal_rgb` holds red in [23:16], green in [15:8] and blue in [7:0]. Indices 0 to 7 map to 000000, 7F0000, 007F00, 00007F, FF0000, 00FF00, 0000FF and FFFFFF. Indices 8 to 255 map to 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access in this cycle |
| bus_off | input | 3 | Register offset |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| refresh_pulse | output | 1 | One-cycle display refresh request |
| err_flag | output | 1 | Sticky access error |
| pal_idx | input | 8 | Pixel index for colour lookup |
| pal_rgb | output | 24 | RGB colour of pal_idx |

## Verification
The hardest case to reach is an out-of-range pixel write that lands on a real storage location. With the column set to IMG_W on row 0, the computed linear address equals that of row 1, column 0. A write there would corrupt a visible pixel if the bounds gate were missing. The stimulus first plants a known value at row 1, column 0, then writes a different value through the aliasing position, and reads the planted pixel back. The error flag is checked around this sequence. A separate test resets the block before exercising the sticky flag, so each error cause is observed on its own.

// File: rtl/pixfb_pkg.sv
// pixfb_pkg: shared definitions for the pixel framebuffer controller.
// Holds the read-source selector type and the colour table generator.
// Assumes 8-bit channels packed as red, green, blue from MSB down.
package pixfb_pkg;

    // Source of the data returned in the read-valid cycle
    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_ROW  = 2'd1,
        RD_COL  = 2'd2,
        RD_PIX  = 2'd3
    } rd_src_e;

    localparam logic [7:0] LVL_HALF = 8'h7F;
    localparam logic [7:0] LVL_FULL = 8'hFF;

    // Colour of table slot i: 0 black, 1-3 half R/G/B, 4-6 full R/G/B, 7 white
    function automatic logic [23:0] pal_entry(input int unsigned i);
        logic [7:0]  lvl;
        int unsigned ch;
        lvl = (i >= 4) ? LVL_FULL : LVL_HALF;
        ch  = (i == 0) ? 0 : ((i - 1) % 3);
        if (i == 0)
            return 24'h000000;
        else if (i == 7)
            return 24'hFFFFFF;
        else
            return {lvl, 16'h0000} >> (8 * ch);
    endfunction

endpackage

// File: rtl/pixfb_regs.sv
// pixfb_regs: bus decode, row/column registers, read return register,
// refresh strobe and sticky error flag.
// Assumes one access per cycle; reads are answered one cycle later.
// in_bounds comes from the pixel store and depends only on row/column.
module pixfb_regs
    import pixfb_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [OFF_W-1:0] off,
    input  logic             we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             in_bounds,
    output logic [BUS_W-1:0] row_q,
    output logic [BUS_W-1:0] col_q,
    output logic             pix_wr,
    output logic             pix_rd,
    output logic             rvalid_q,
    output rd_src_e          rd_src_q,
    output logic [BUS_W-1:0] reg_rdata_q,
    output logic             refresh_q,
    output logic             err_q
);

    localparam logic [OFF_W-1:0] O_ROW = OFF_W'(0);
    localparam logic [OFF_W-1:0] O_COL = OFF_W'(1);
    localparam logic [OFF_W-1:0] O_PIX = OFF_W'(2);
    localparam logic [OFF_W-1:0] O_REF = OFF_W'(3);

    logic acc_row, acc_col, acc_pix, acc_ref, acc_bad;
    logic err_set;

    // Decode the offset of the current access
    always_comb begin
        acc_row = sel && (off == O_ROW);
        acc_col = sel && (off == O_COL);
        acc_pix = sel && (off == O_PIX);
        acc_ref = sel && (off == O_REF);
        acc_bad = sel && (off > O_REF);
        pix_wr  = acc_pix && we && in_bounds;
        pix_rd  = acc_pix && !we && in_bounds;
        err_set = acc_bad || (acc_pix && !we && !in_bounds);
    end

    // Row and column registers, written only through their own offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (acc_row && we) row_q <= wdata;
            if (acc_col && we) col_q <= wdata;
        end
    end

    // Capture read source and register data for the read-valid cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q    <= 1'b0;
            rd_src_q    <= RD_ZERO;
            reg_rdata_q <= '0;
        end else begin
            rvalid_q <= sel && !we;
            if (sel && !we) begin
                if (acc_row) begin
                    rd_src_q    <= RD_ROW;
                    reg_rdata_q <= row_q;
                end else if (acc_col) begin
                    rd_src_q    <= RD_COL;
                    reg_rdata_q <= col_q;
                end else if (pix_rd) begin
                    rd_src_q    <= RD_PIX;
                    reg_rdata_q <= '0;
                end else begin
                    rd_src_q    <= RD_ZERO;
                    reg_rdata_q <= '0;
                end
            end
        end
    end

    // Refresh strobe: one cycle per write to the refresh offset
    always_ff @(posedge clk) begin
        if (!rst_n) refresh_q <= 1'b0;
        else        refresh_q <= acc_ref && we;
    end

    // Sticky error flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    // R1: row/column only change after a write to their own offset
    a_r1_row_written_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_q) |-> $past(sel && we && off == O_ROW));
    a_r1_col_written_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(col_q) |-> $past(sel && we && off == O_COL));

endmodule

// File: rtl/pixfb_store.sv
// pixfb_store: pixel storage with bounds check and linear addressing.
// Address is row * IMG_W + col; accesses outside the frame are gated off.
// Synchronous single-port array, one-cycle read latency; no reset on contents.
module pixfb_store #(
    parameter int BUS_W = 16,
    parameter int PIX_W = 8,
    parameter int IMG_W = 64,
    parameter int IMG_H = 48
) (
    input  logic             clk,
    input  logic [BUS_W-1:0] row_i,
    input  logic [BUS_W-1:0] col_i,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [PIX_W-1:0] wdata,
    output logic             in_bounds,
    output logic [PIX_W-1:0] rdata_q
);

    localparam int DEPTH  = IMG_W * IMG_H;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [BUS_W-1:0] W_LIM = BUS_W'(IMG_W);
    localparam logic [BUS_W-1:0] H_LIM = BUS_W'(IMG_H);

    logic [PIX_W-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] addr;

    // Bounds check and linear address from the latched position
    always_comb begin
        in_bounds = (row_i < H_LIM) && (col_i < W_LIM);
        addr      = ADDR_W'(32'(row_i) * 32'(IMG_W) + 32'(col_i));
    end

    // Pixel write port
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Pixel read port, registered
    always_ff @(posedge clk) begin
        if (rd_en) rdata_q <= mem[addr];
    end

endmodule

// File: rtl/pixfb_palette.sv
// pixfb_palette: fixed colour table turning a pixel index into 24-bit RGB.
// Purely combinational; indices past the table map to black.
module pixfb_palette
    import pixfb_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int PAL_N = 8
) (
    input  logic [PIX_W-1:0] idx,
    output logic [23:0]      rgb
);

    localparam int SEL_W = $clog2(PAL_N);
    localparam logic [PIX_W-1:0] N_LIM = PIX_W'(PAL_N);

    logic [23:0] tbl [PAL_N];

    // Build every table slot from the colour rule
    for (genvar i = 0; i < PAL_N; i++) begin : g_slot
        assign tbl[i] = pal_entry(i);
    end

    // Select the slot, or black beyond the table
    always_comb begin
        rgb = (idx < N_LIM) ? tbl[idx[SEL_W-1:0]] : 24'h000000;
    end

endmodule

// File: rtl/pixfb_ctrl.sv
// pixfb_ctrl: register-addressed pixel framebuffer controller (top).
// Offsets: 0 row, 1 column, 2 pixel data, 3 refresh strobe, 4+ invalid.
// Assumes a simple synchronous bus, one access per cycle; reads return
// data with bus_rvalid one cycle later. Colour port is independent.
module pixfb_ctrl
    import pixfb_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int OFF_W = 3,
    parameter int PIX_W = 8,
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    parameter int PAL_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic [OFF_W-1:0] bus_off,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             bus_rvalid,
    output logic             refresh_pulse,
    output logic             err_flag,
    input  logic [PIX_W-1:0] pal_idx,
    output logic [23:0]      pal_rgb
);

    logic [BUS_W-1:0] row_q, col_q, reg_rdata_q;
    logic             pix_wr, pix_rd, in_bounds;
    logic [PIX_W-1:0] pix_q;
    rd_src_e          rd_src_q;

    pixfb_regs #(.BUS_W(BUS_W), .OFF_W(OFF_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .off        (bus_off),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .in_bounds  (in_bounds),
        .row_q      (row_q),
        .col_q      (col_q),
        .pix_wr     (pix_wr),
        .pix_rd     (pix_rd),
        .rvalid_q   (bus_rvalid),
        .rd_src_q   (rd_src_q),
        .reg_rdata_q(reg_rdata_q),
        .refresh_q  (refresh_pulse),
        .err_q      (err_flag)
    );

    pixfb_store #(.BUS_W(BUS_W), .PIX_W(PIX_W), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_store (
        .clk      (clk),
        .row_i    (row_q),
        .col_i    (col_q),
        .wr_en    (pix_wr),
        .rd_en    (pix_rd),
        .wdata    (bus_wdata[PIX_W-1:0]),
        .in_bounds(in_bounds),
        .rdata_q  (pix_q)
    );

    pixfb_palette #(.PIX_W(PIX_W), .PAL_N(PAL_N)) u_pal (
        .idx(pal_idx),
        .rgb(pal_rgb)
    );

    // Return path: zero-extended pixel or the captured register value
    always_comb begin
        if (rd_src_q == RD_PIX) bus_rdata = {{(BUS_W-PIX_W){1'b0}}, pix_q};
        else                    bus_rdata = reg_rdata_q;
    end

    // R4: a refresh pulse follows a write to the refresh offset
    a_r4_refresh_cause: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |-> $past(bus_sel && bus_we && bus_off == OFF_W'(3)));

    // R5: read-valid only after an accepted read
    a_r5_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_we));

    // R6: reads of invalid offsets return zero
    a_r6_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_off > OFF_W'(3))) |-> (bus_rdata == '0));

    // R9: the error flag never clears outside reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R3: pixel read data never carries bits above the pixel width
    a_r3_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_off == OFF_W'(2))) |-> (bus_rdata[BUS_W-1:PIX_W] == '0));

endmodule

// File: tb/sim_pixfb_ctrl.sv
// Directed bench for pixfb_ctrl at default geometry (64 x 48).
module sim_pixfb_ctrl;

    localparam int W = 64;
    localparam int H = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [2:0]  bus_off = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        refresh_pulse;
    logic        err_flag;
    logic [7:0]  pal_idx = '0;
    logic [23:0] pal_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pixfb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_off(bus_off),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .refresh_pulse(refresh_pulse),
        .err_flag(err_flag), .pal_idx(pal_idx), .pal_rgb(pal_rgb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [2:0] off, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] off, output logic [15:0] d, output logic v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_off = off;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        v = bus_rvalid;
    endtask

    task automatic set_pos(input logic [15:0] r, input logic [15:0] c);
        bus_write(3'd0, r);
        bus_write(3'd1, c);
    endtask

    task automatic t_reset();
        logic [15:0] d; logic v;
        chk("R9 err after reset", 32'(err_flag), 0);
        chk("R4 no refresh after reset", 32'(refresh_pulse), 0);
        chk("R5 no rvalid after reset", 32'(bus_rvalid), 0);
        bus_read(3'd0, d, v);
        chk("R1 row reset", 32'(d), 0);
        bus_read(3'd1, d, v);
        chk("R1 col reset", 32'(d), 0);
    endtask

    task automatic t_regs();
        logic [15:0] d; logic v;
        set_pos(16'hABCD, 16'h1234);
        bus_read(3'd0, d, v);
        chk("R1 row 16-bit readback", 32'(d), 32'hABCD);
        bus_read(3'd1, d, v);
        chk("R1 col 16-bit readback", 32'(d), 32'h1234);
    endtask

    task automatic t_pixel();
        logic [15:0] d; logic v;
        set_pos(5, 17);
        bus_write(3'd2, 16'h12A5);
        set_pos(6, 0);
        bus_write(3'd2, 16'h003C);
        set_pos(H-1, W-1);
        bus_write(3'd2, 16'hFFFF);
        set_pos(5, 17);
        bus_read(3'd2, d, v);
        chk("R3 pixel (5,17) zero-extended low byte", 32'(d), 32'h00A5);
        chk("R5 rvalid on pixel read", 32'(v), 1);
        set_pos(6, 0);
        bus_read(3'd2, d, v);
        chk("R2 pixel (6,0) distinct", 32'(d), 32'h003C);
        set_pos(H-1, W-1);
        bus_read(3'd2, d, v);
        chk("R2 last pixel", 32'(d), 32'h00FF);
        bus_write(3'd2, 16'h0042);
        bus_read(3'd0, d, v);
        chk("R1 row held after pixel access", 32'(d), H-1);
        bus_read(3'd1, d, v);
        chk("R1 col held after pixel access", 32'(d), W-1);
        bus_read(3'd2, d, v);
        chk("R2 overwrite last pixel", 32'(d), 32'h0042);
        chk("R9 no error from good accesses", 32'(err_flag), 0);
    endtask

    task automatic t_rvalid();
        logic [15:0] d; logic v;
        bus_write(3'd0, 16'h0003);
        chk("R5 no rvalid after write", 32'(bus_rvalid), 0);
        bus_read(3'd0, d, v);
        chk("R5 rvalid after read", 32'(v), 1);
        chk("R5 read data with rvalid", 32'(d), 3);
        @(negedge clk);
        chk("R5 rvalid lasts one cycle", 32'(bus_rvalid), 0);
    endtask

    task automatic t_refresh();
        logic [15:0] d; logic v;
        set_pos(5, 17);
        bus_write(3'd3, 16'h0000);
        chk("R4 refresh pulse after write", 32'(refresh_pulse), 1);
        @(negedge clk);
        chk("R4 refresh pulse one cycle", 32'(refresh_pulse), 0);
        bus_read(3'd3, d, v);
        chk("R4 refresh read zero", 32'(d), 0);
        chk("R4 refresh read no pulse", 32'(refresh_pulse), 0);
        bus_read(3'd0, d, v);
        chk("R4 row untouched by refresh", 32'(d), 5);
        bus_read(3'd1, d, v);
        chk("R4 col untouched by refresh", 32'(d), 17);
        bus_read(3'd2, d, v);
        chk("R4 pixel untouched by refresh", 32'(d), 32'h00A5);
    endtask

    task automatic t_oob_write();
        logic [15:0] d; logic v;
        set_pos(1, 0);
        bus_write(3'd2, 16'h0077);
        set_pos(0, W);
        bus_write(3'd2, 16'h0099);
        set_pos(H, 0);
        bus_write(3'd2, 16'h0055);
        set_pos(1, 0);
        bus_read(3'd2, d, v);
        chk("R7 aliased pixel unchanged", 32'(d), 32'h0077);
    endtask

    task automatic t_oob_read();
        logic [15:0] d; logic v;
        chk("R8 err clear before oob read", 32'(err_flag), 0);
        set_pos(0, W);
        bus_read(3'd2, d, v);
        chk("R8 oob read returns zero", 32'(d), 0);
        chk("R8 oob read sets error", 32'(err_flag), 1);
        set_pos(1, 0);
        bus_read(3'd2, d, v);
        chk("R9 error stays set", 32'(err_flag), 1);
        do_reset();
        chk("R9 reset clears error", 32'(err_flag), 0);
    endtask

    task automatic t_bad_off();
        logic [15:0] d; logic v;
        set_pos(7, 9);
        bus_write(3'd5, 16'h1111);
        chk("R6 bad write sets error", 32'(err_flag), 1);
        bus_read(3'd0, d, v);
        chk("R6 row untouched", 32'(d), 7);
        bus_read(3'd1, d, v);
        chk("R6 col untouched", 32'(d), 9);
        bus_read(3'd7, d, v);
        chk("R6 bad read rvalid", 32'(v), 1);
        chk("R6 bad read zero", 32'(d), 0);
        set_pos(1, 0);
        bus_read(3'd2, d, v);
        chk("R6 pixel untouched", 32'(d), 32'h0077);
    endtask

    function automatic logic [23:0] exp_rgb(input int i);
        case (i)
            0: return 24'h000000;
            1: return 24'h7F0000;
            2: return 24'h007F00;
            3: return 24'h00007F;
            4: return 24'hFF0000;
            5: return 24'h00FF00;
            6: return 24'h0000FF;
            7: return 24'hFFFFFF;
            default: return 24'h000000;
        endcase
    endfunction

    task automatic t_palette();
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pal_idx = 8'(i);
            #1;
            chk("R10 palette colour", 32'(pal_rgb), 32'(exp_rgb(i)));
        end
    endtask

    initial begin
        do_reset();
        t_reset();
        t_regs();
        t_pixel();
        t_rvalid();
        t_refresh();
        t_oob_write();
        t_oob_read();
        t_bad_off();
        t_palette();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule